// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block runs the element loop of a vector operation that carries one predicate for its sources and a separate predicate for its destinations. A start pulse captures a vector length, a starting step for each side, a mask mode for each side, and base register numbers. The block then issues (source element, destination element) pairs. Each pair joins the next source element whose mask bit is set with the next destination element whose mask bit is set. The result is a compress on the source side followed by an expand on the destination side, and it works for any operation the surrounding pipeline applies.

Each mask can be all ones, an integer register value, its inverse, a one-hot value built from a register, or one bit picked from each condition-register field starting at a shared base field. A priority encoder jumps over any run of cleared mask bits above the current step in one cycle, so a pair is offered on every cycle while pairs remain. When either side runs out below the vector length, the block pulses `done` and reports the step reached on each side, so an interrupted loop can be restarted.

Top module: `twin_pred_seq`

## Requirements
- R1: A source element i is used only when bit i of the source mask is 1. Cleared source bits are passed over, and later enabled elements are compressed toward earlier destinations.
- R2: A destination element j receives a pair only when bit j of the destination mask is 1. Cleared destination positions are never named in any pair.
- R3: Pairs are issued in increasing order on both sides. The k-th enabled source element goes with the k-th enabled destination element. `out_valid` is high on every cycle of the run while a pair remains, starting the cycle after the start pulse is accepted.
- R4: The run ends as soon as no enabled element remains below VL on either side. One cycle later `done` is high for exactly one cycle and `busy` falls. `final_src_step` and `final_dst_step` then give, for each side, the first enabled index at or above its current step, or VL if there is none. After reset the block is idle, with `busy`, `out_valid` and `done` all low.
- R5: Mask bits below `src_step_in` and `dst_step_in` are ignored. With VL=4, source step 1, destination step 2, source mask 0b0101 and destination mask 0b1010, the only pair is (2,3).
- R6: Mode encodings: 0 gives all ones, 1 gives the integer value, 2 gives its bitwise inverse, 3 gives 1 shifted left by the low log2(MAX_VL) bits of the integer value, 4 selects condition-register bits, and 5 to 7 give an empty mask.
- R7: In mode 4, mask bit i is bit `crsel` of condition-register field (cr_base+i) mod CR_FIELDS. Field f occupies `cr_bits[4f+3:4f]`, so the selected bit is `cr_bits[4f+crsel]`. The two sides may use different `crsel` values with the same base.
- R8: `out_src_reg` equals (src_base + source index) mod 2^REG_W, and `out_dst_reg` equals (dst_base + destination index) mod 2^REG_W.
- R9: Mask bits at or above VL never produce a pair. VL=0 ends the run with no pairs.
- R10: While `out_valid` is high and `out_ready` is low, the offered pair and its register numbers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures the loop setup when idle |
| vl | input | IDX_W | Vector length, 0..MAX_VL |
| src_step_in | input | IDX_W | Starting source step |
| dst_step_in | input | IDX_W | Starting destination step |
| src_mode | input | 3 | Source mask mode |
| dst_mode | input | 3 | Destination mask mode |
| src_ival | input | MAX_VL | Integer value for the source mask |
| dst_ival | input | MAX_VL | Integer value for the destination mask |
| src_crsel | input | 2 | Bit taken from each CR field, source |
| dst_crsel | input | 2 | Bit taken from each CR field, destination |
| cr_base | input | CRF_W | First CR field used by mode 4 |
| cr_bits | input | 4*CR_FIELDS | Flattened condition-register fields |
| src_base | input | REG_W | Source vector base register |
| dst_base | input | REG_W | Destination vector base register |
| busy | output | 1 | Loop in progress |
| out_valid | output | 1 | A pair is offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src_idx | output | IDX_W | Source element index |
| out_dst_idx | output | IDX_W | Destination element index |
| out_src_reg | output | REG_W | Source register number |
| out_dst_reg | output | REG_W | Destination register number |
| done | output | 1 | One-cycle end-of-run pulse |
| final_src_step | output | IDX_W | Source step reached at the end |
| final_dst_step | output | IDX_W | Destination step reached at the end |

## Verification
The bench uses the default parameters: MAX_VL=64, CR_FIELDS=128 and REG_W=7. The full 64-element run therefore reaches the top step value of 64. The condition-register base can wrap from field 127 to field 0, and base-plus-index register numbers wrap past 127. A long all-ones run with irregular back-pressure covers both the single-cycle offer rate and the hold behaviour across many stalls. Short runs taken from the compress, expand, resume, one-hot and condition-register patterns pin down the exact pairing and the final step values.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  typedef enum logic [2:0] {
    PM_ALL    = 3'd0,
    PM_INT    = 3'd1,
    PM_INV    = 3'd2,
    PM_ONEHOT = 3'd3,
    PM_CR     = 3'd4
  } pmode_e;
endpackage

// File: rtl/tps_mask_gen.sv
`timescale 1ns/1ps
module tps_mask_gen #(
  parameter int MAX_VL    = 64,
  parameter int CR_FIELDS = 128,
  localparam int SH_W     = $clog2(MAX_VL),
  localparam int CRF_W    = $clog2(CR_FIELDS)
) (
  input  logic [2:0]             mode,
  input  logic [MAX_VL-1:0]      ival,
  input  logic [1:0]             crsel,
  input  logic [CRF_W-1:0]       cr_base,
  input  logic [4*CR_FIELDS-1:0] cr_bits,
  output logic [MAX_VL-1:0]      mask
);
  import tps_pkg::*;

  logic [MAX_VL-1:0] cr_mask;

  // one bit per element, taken from consecutive CR fields (wrapping)
  always_comb begin
    for (int i = 0; i < MAX_VL; i++) begin
      logic [CRF_W-1:0] fld;
      fld = cr_base + CRF_W'(i);
      cr_mask[i] = cr_bits[{fld, crsel}];
    end
  end

  always_comb begin
    case (pmode_e'(mode))
      PM_ALL:    mask = '1;
      PM_INT:    mask = ival;
      PM_INV:    mask = ~ival;
      PM_ONEHOT: mask = MAX_VL'(1) << ival[SH_W-1:0];
      PM_CR:     mask = cr_mask;
      default:   mask = '0;
    endcase
  end
endmodule

// File: rtl/tps_scan.sv
`timescale 1ns/1ps
module tps_scan #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic [IDX_W-1:0]  step,
  input  logic [IDX_W-1:0]  vl,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  // lowest set bit of mask in the window [step, vl)
  function automatic logic [IDX_W:0] first_enabled(
    input logic [MAX_VL-1:0] m,
    input logic [IDX_W-1:0]  lo,
    input logic [IDX_W-1:0]  hi
  );
    logic [IDX_W:0] r;
    r = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (m[i] && (IDX_W'(i) >= lo) && (IDX_W'(i) < hi)) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  always_comb begin
    {found, idx} = first_enabled(mask, step, vl);
  end
endmodule

// File: rtl/twin_pred_seq.sv
`timescale 1ns/1ps
module twin_pred_seq #(
  parameter int MAX_VL    = 64,
  parameter int CR_FIELDS = 128,
  parameter int REG_W     = 7,
  localparam int IDX_W    = $clog2(MAX_VL + 1),
  localparam int CRF_W    = $clog2(CR_FIELDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [IDX_W-1:0]       vl,
  input  logic [IDX_W-1:0]       src_step_in,
  input  logic [IDX_W-1:0]       dst_step_in,
  input  logic [2:0]             src_mode,
  input  logic [2:0]             dst_mode,
  input  logic [MAX_VL-1:0]      src_ival,
  input  logic [MAX_VL-1:0]      dst_ival,
  input  logic [1:0]             src_crsel,
  input  logic [1:0]             dst_crsel,
  input  logic [CRF_W-1:0]       cr_base,
  input  logic [4*CR_FIELDS-1:0] cr_bits,
  input  logic [REG_W-1:0]       src_base,
  input  logic [REG_W-1:0]       dst_base,
  output logic                   busy,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [IDX_W-1:0]       out_src_idx,
  output logic [IDX_W-1:0]       out_dst_idx,
  output logic [REG_W-1:0]       out_src_reg,
  output logic [REG_W-1:0]       out_dst_reg,
  output logic                   done,
  output logic [IDX_W-1:0]       final_src_step,
  output logic [IDX_W-1:0]       final_dst_step
);
  logic [MAX_VL-1:0] src_mask_d, dst_mask_d, src_mask_q, dst_mask_q;
  logic [IDX_W-1:0]  vl_q, src_step_q, dst_step_q;
  logic [REG_W-1:0]  src_base_q, dst_base_q;
  logic              s_found, d_found;
  logic [IDX_W-1:0]  s_idx, d_idx;
  logic              pair_fire, run_end;

  tps_mask_gen #(.MAX_VL(MAX_VL), .CR_FIELDS(CR_FIELDS)) u_src_mask (
    .mode(src_mode), .ival(src_ival), .crsel(src_crsel),
    .cr_base(cr_base), .cr_bits(cr_bits), .mask(src_mask_d));

  tps_mask_gen #(.MAX_VL(MAX_VL), .CR_FIELDS(CR_FIELDS)) u_dst_mask (
    .mode(dst_mode), .ival(dst_ival), .crsel(dst_crsel),
    .cr_base(cr_base), .cr_bits(cr_bits), .mask(dst_mask_d));

  tps_scan #(.MAX_VL(MAX_VL)) u_src_scan (
    .mask(src_mask_q), .step(src_step_q), .vl(vl_q),
    .found(s_found), .idx(s_idx));

  tps_scan #(.MAX_VL(MAX_VL)) u_dst_scan (
    .mask(dst_mask_q), .step(dst_step_q), .vl(vl_q),
    .found(d_found), .idx(d_idx));

  assign out_valid   = busy && s_found && d_found;
  assign run_end     = busy && !(s_found && d_found);
  assign pair_fire   = out_valid && out_ready;
  assign out_src_idx = s_idx;
  assign out_dst_idx = d_idx;
  assign out_src_reg = src_base_q + REG_W'(s_idx);
  assign out_dst_reg = dst_base_q + REG_W'(d_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      done           <= 1'b0;
      vl_q           <= '0;
      src_step_q     <= '0;
      dst_step_q     <= '0;
      src_mask_q     <= '0;
      dst_mask_q     <= '0;
      src_base_q     <= '0;
      dst_base_q     <= '0;
      final_src_step <= '0;
      final_dst_step <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy       <= 1'b1;
          vl_q       <= vl;
          src_step_q <= src_step_in;
          dst_step_q <= dst_step_in;
          src_mask_q <= src_mask_d;
          dst_mask_q <= dst_mask_d;
          src_base_q <= src_base;
          dst_base_q <= dst_base;
        end
      end else if (run_end) begin
        busy           <= 1'b0;
        done           <= 1'b1;
        final_src_step <= s_found ? s_idx : vl_q;
        final_dst_step <= d_found ? d_idx : vl_q;
      end else if (pair_fire) begin
        src_step_q <= s_idx + IDX_W'(1);
        dst_step_q <= d_idx + IDX_W'(1);
      end
    end
  end

  AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> src_mask_q[out_src_idx[IDX_W-2:0]]);                       // R1
  AST_DST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dst_mask_q[out_dst_idx[IDX_W-2:0]]);                       // R2
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> !out_valid || ((out_src_idx > $past(out_src_idx)) &&
                                 (out_dst_idx > $past(out_dst_idx))));       // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                         // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);                                           // R4
  AST_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_src_idx < vl_q) && (out_dst_idx < vl_q));             // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src_idx) &&
                                 $stable(out_dst_idx));                      // R10
endmodule

// File: tb/twin_pred_seq_bench.sv
`timescale 1ns/1ps
module twin_pred_seq_bench;
  localparam int MAX_VL = 64, CR_FIELDS = 128, REG_W = 7, IDX_W = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [IDX_W-1:0] vl = '0, src_step_in = '0, dst_step_in = '0;
  logic [2:0] src_mode = '0, dst_mode = '0;
  logic [63:0] src_ival = '0, dst_ival = '0;
  logic [1:0] src_crsel = '0, dst_crsel = '0;
  logic [6:0] cr_base = '0;
  logic [511:0] cr_bits = '0;
  logic [REG_W-1:0] src_base = '0, dst_base = '0;
  logic busy, out_valid, done;
  logic [IDX_W-1:0] out_src_idx, out_dst_idx, final_src_step, final_dst_step;
  logic [REG_W-1:0] out_src_reg, out_dst_reg;

  int checks = 0, failures = 0;
  bit stall_mode = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  twin_pred_seq u_twin_pred_seq (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mask(int mode, logic [63:0] iv, int sel);
    logic [63:0] m;
    case (mode)
      0: m = '1;
      1: m = iv;
      2: m = ~iv;
      3: m = 64'd1 << iv[5:0];
      4: for (int i = 0; i < 64; i++) m[i] = cr_bits[((int'(cr_base) + i) % 128) * 4 + sel];
      default: m = '0;
    endcase
    return m;
  endfunction

  task automatic run_case(string tag);
    int qs[$], qd[$];
    int s, d, n, fs, fd;
    logic [63:0] sm, dm;
    bit rdy;
    sm = ref_mask(src_mode, src_ival, src_crsel);
    dm = ref_mask(dst_mode, dst_ival, dst_crsel);
    n = vl; s = src_step_in; d = dst_step_in;
    forever begin
      while (s < n && !sm[s]) s++;
      while (d < n && !dm[d]) d++;
      if (s >= n || d >= n) break;
      qs.push_back(s); qd.push_back(d);
      s++; d++;
    end
    fs = (s < n) ? s : n;
    fd = (d < n) ? d : n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      chk(out_valid === (qs.size() > 0), "R3", {tag, " valid"}, out_valid, qs.size() > 0);
      if (qs.size() == 0) break;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rdy = stall_mode ? lf[0] : 1'b1;
      out_ready = rdy;
      chk(out_src_idx == qs[0], rdy ? tag : "R10", {tag, " src idx"}, out_src_idx, qs[0]);
      chk(out_dst_idx == qd[0], rdy ? tag : "R10", {tag, " dst idx"}, out_dst_idx, qd[0]);
      chk(out_src_reg == REG_W'(int'(src_base) + qs[0]), "R8", {tag, " src reg"},
          out_src_reg, (int'(src_base) + qs[0]) % 128);
      chk(out_dst_reg == REG_W'(int'(dst_base) + qd[0]), "R8", {tag, " dst reg"},
          out_dst_reg, (int'(dst_base) + qd[0]) % 128);
      if (rdy) begin
        void'(qs.pop_front()); void'(qd.pop_front());
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(done === 1'b0, "R4", {tag, " done early"}, done, 0);
    @(negedge clk);
    chk(done === 1'b1, "R4", {tag, " done"}, done, 1);
    chk(busy === 1'b0, "R4", {tag, " busy"}, busy, 0);
    chk(final_src_step == fs, "R4", {tag, " final src"}, final_src_step, fs);
    chk(final_dst_step == fd, "R4", {tag, " final dst"}, final_dst_step, fd);
    @(negedge clk);
    chk(done === 1'b0, "R4", {tag, " done width"}, done, 0);
  endtask

  task automatic setup(int n, int ss, int ds, int smd, int dmd,
                       logic [63:0] si, logic [63:0] di);
    vl = IDX_W'(n); src_step_in = IDX_W'(ss); dst_step_in = IDX_W'(ds);
    src_mode = 3'(smd); dst_mode = 3'(dmd); src_ival = si; dst_ival = di;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: idle after reset
    chk(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R4", "reset idle",
        {busy, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    src_base = 7'd9; dst_base = 7'd5;
    // R1/R2 twin: inverse src 0b10 -> 0b01, dst 0b10 -> (0,1)
    setup(2, 0, 0, 2, 1, 64'h2, 64'h2); run_case("R1");
    // R1 compress: src 0b101, dst all -> (0,0),(2,1)
    setup(3, 0, 0, 1, 0, 64'h5, 64'h0); run_case("R1");
    // R2 expand: src all, dst 0b101 -> (0,0),(1,2)
    setup(3, 0, 0, 0, 1, 64'h0, 64'h5); run_case("R2");
    // R6 inverse on dst: src 0b101, dst ~0b101 -> (0,1)
    setup(3, 0, 0, 1, 2, 64'h5, 64'h5); run_case("R6");
    // R5 resume: srcstep 1, dststep 2 -> (2,3)
    setup(4, 1, 2, 1, 2, 64'h5, 64'h5); run_case("R5");
    // R6 one-hot dst 1<<1 with src 0b100 -> (2,1)
    setup(3, 0, 0, 1, 3, 64'h4, 64'h1); run_case("R6");
    // R6 one-hot src 1<<2 with dst 0b010 -> (2,1)
    setup(3, 0, 0, 3, 1, 64'h2, 64'h2); run_case("R6");
    // R6 reserved mode gives empty mask: no pairs
    setup(5, 0, 0, 5, 0, 64'h0, 64'h0); run_case("R6");
    // R7 CR: base 4, src bit 2 on fields 4,6, dst bit 0 on fields 5,7, resume 1/2 -> (2,3)
    cr_bits = '0; cr_bits[18] = 1'b1; cr_bits[26] = 1'b1; cr_bits[20] = 1'b1; cr_bits[28] = 1'b1;
    cr_base = 7'd4; src_crsel = 2'd2; dst_crsel = 2'd0;
    setup(4, 1, 2, 4, 4, 64'h0, 64'h0); run_case("R7");
    // R7 CR base wraps 127 -> 0
    cr_bits = '0; cr_bits[127*4+1] = 1'b1; cr_bits[0*4+1] = 1'b1;
    cr_base = 7'd126; src_crsel = 2'd1;
    setup(4, 0, 0, 4, 0, 64'h0, 64'h0); run_case("R7");
    // R9 VL=0 and bits at/above VL
    setup(0, 0, 0, 0, 0, 64'h0, 64'h0); run_case("R9");
    setup(2, 0, 0, 1, 0, 64'hF0, 64'h0); run_case("R9");
    // R8/R10 full length with register wrap and random stalls
    src_base = 7'd100; dst_base = 7'd90; stall_mode = 1'b1;
    setup(64, 0, 0, 0, 0, 64'h0, 64'h0); run_case("R3");
    setup(64, 3, 0, 1, 2, 64'hA5A5_0F0F_3C3C_9999, 64'h1234_5678_9ABC_DEF0); run_case("R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule